// File: doc/BRIEF.md
# HARQ Soft-Value Combiner

This block sits between a derate matcher that produces soft values (signed log-likelihood ratios, `LLR_W` bits each) and one or two LDPC decoder input streams. A two-word parameter load prepares each code block. For a retransmission, the block fetches the soft values that were combined earlier from external memory through a memory-mapped master. It adds them lane by lane to the freshly received values with saturation, writes the sums back to the same location, and forwards them to a decoder stream. For a first transmission combining is switched off. The new values then pass through unchanged and are still stored, so they are ready for the next attempt.

Each input beat carries `NLANE` (32) values, lane 0 in the least significant bits. Beat `b` of a block maps to memory word `base + b`, and one memory word holds one beat. A control state machine handles the beats one after another, in these states: `S_IDLE` waits for the first parameter word and goes to `S_CFG1`. `S_CFG1` waits for the second word and goes to `S_FETCH`. `S_FETCH` pops one input beat when one is available. It goes to `S_RD_REQ` if any lane of the beat lies inside the old length and combining is on, and to `S_MERGE` otherwise. `S_RD_REQ` holds a read until it is accepted and then goes to `S_RD_WAIT`. `S_RD_WAIT` waits for the read data and goes to `S_MERGE`. `S_MERGE` registers the saturated sums and goes to `S_WR_REQ`. `S_WR_REQ` holds a write until it is accepted and then goes to `S_EMIT`. `S_EMIT` waits until the selected stream is not almost full and writes the beat there. It then goes back to `S_FETCH`, or to `S_IDLE` after the last beat.

Top module: `harq_combiner`

## Requirements
- R1: A parameter load is two consecutive `cfg_wr` cycles. In word 0, bit 31 = 1 disables combining and bits [25:0] give the memory base address. In word 1, bits [14:0] give the old length (stored values to combine) and bits [30:16] give the codeword length L. A block has ceil(L/32) beats, or one beat when L is 0.
- R2: While `rst_n` is low, `in_rd`, `mem_read`, `mem_write`, `d0_wr` and `d1_wr` are all low.
- R3: Input is pulled one beat at a time. `in_rd` is high only while `in_avail` is high, and every beat of the block is consumed exactly once, however long `in_avail` stays low.
- R4: With combining on, beat b is read from address base+b when b*32 is below the old length, and not otherwise. Lane j of beat b adds the stored value when b*32+j is below the old length, and uses zero in place of the stored value otherwise.
- R5: Each sum saturates to the signed range of `LLR_W` bits, -32 to +31 for `LLR_W` = 6.
- R6: With combining off, no read is issued, and every output and stored value equals the new input value.
- R7: Every beat is written to address base+b with the combined values in the low 32*`LLR_W` bits, before it is sent to a decoder.
- R8: While `mem_waitreq` is high, a pending read or write is held with the same address (and the same write data).
- R9: Each block produces exactly one decoder write per beat, with start-of-packet on beat 0 and end-of-packet on the last beat (both on a single-beat block).
- R10: With two decoder streams, consecutive blocks alternate between stream 0 and stream 1, starting with stream 0 after reset. At most one stream is written in any cycle.
- R11: A stream is never written while its almost-full input is high. The beat waits and is delivered unchanged afterwards.
- R12: `cfg_wr` is ignored while a block is in progress, with no effect on addresses, data or framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Parameter word strobe |
| cfg_data | input | 32 | Parameter word |
| in_avail | input | 1 | Input beat available |
| in_rd | output | 1 | Pops the current input beat |
| in_data | input | NLANE*LLR_W | 32 new soft values, lane 0 lowest |
| mem_addr | output | ADDR_W | Memory word address |
| mem_read | output | 1 | Read request |
| mem_write | output | 1 | Write request |
| mem_wdata | output | MEM_W | Write data |
| mem_rdata | input | MEM_W | Read data |
| mem_rvalid | input | 1 | Read data valid |
| mem_waitreq | input | 1 | Memory stalls the current request |
| d0_wr | output | 1 | Stream 0 write |
| d0_sop | output | 1 | Stream 0 start of packet |
| d0_eop | output | 1 | Stream 0 end of packet |
| d0_data | output | NLANE*LLR_W | Stream 0 combined values |
| d0_afull | input | 1 | Stream 0 almost full |
| d1_wr | output | 1 | Stream 1 write |
| d1_sop | output | 1 | Stream 1 start of packet |
| d1_eop | output | 1 | Stream 1 end of packet |
| d1_data | output | NLANE*LLR_W | Stream 1 combined values |
| d1_afull | input | 1 | Stream 1 almost full |

## Verification
A wrong beat counter or a bad old-length compare shows up within one beat. The symptom is a read at the wrong address, a read that is missing or extra, or lanes past the old length that carry a sum instead of the raw input. A stuck stream selector shows up at the next block as a write on the wrong stream. A state machine that drops a request under wait-request shows up as a changed address or a lost write in the same cycle, and as stale memory contents on the next retransmission. A saturation fault only appears for lane pairs near the range limits, so the tests fill lanes with alternating extreme values.

// File: rtl/harq_pkg.sv
package harq_pkg;

    // width of the length fields in the parameter word
    localparam int HQ_LEN_W = 15;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CFG1,
        S_FETCH,
        S_RD_REQ,
        S_RD_WAIT,
        S_MERGE,
        S_WR_REQ,
        S_EMIT
    } hq_state_e;

endpackage

// File: rtl/harq_sat_add.sv
module harq_sat_add #(
    parameter int W = 6
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    logic [W:0] sum;
    logic       pos_ovf;
    logic       neg_ovf;

    assign sum     = {a[W-1], a} + {b[W-1], b};
    assign pos_ovf = !sum[W] && sum[W-1];
    assign neg_ovf = sum[W] && !sum[W-1];

    always_comb begin
        if (pos_ovf)
            y = {1'b0, {(W-1){1'b1}}};
        else if (neg_ovf)
            y = {1'b1, {(W-1){1'b0}}};
        else
            y = sum[W-1:0];
    end

    always_comb begin
        // R5
        if (!a[W-1] && !b[W-1])
            sat_pos_chk: assert (!y[W-1]);
        // R5
        if (a[W-1] && b[W-1])
            sat_neg_chk: assert (y[W-1]);
    end

endmodule

// File: rtl/harq_cfg_regs.sv
module harq_cfg_regs
    import harq_pkg::*;
#(
    parameter int ADDR_W   = 26,
    parameter int LANE_LOG = 5,
    localparam int LEN_W   = HQ_LEN_W,
    localparam int BEAT_W  = LEN_W - LANE_LOG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld0,
    input  logic              ld1,
    input  logic [31:0]       wdata,
    output logic              no_comb,
    output logic [ADDR_W-1:0] base,
    output logic [LEN_W-1:0]  old_len,
    output logic [LEN_W-1:0]  cb_len,
    output logic [BEAT_W-1:0] last_beat
);

    logic [LEN_W-1:0] cb_m1;
    logic             unused_bits;

    assign unused_bits = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            no_comb <= 1'b1;
            base    <= '0;
            old_len <= '0;
            cb_len  <= '0;
        end else begin
            if (ld0) begin
                no_comb <= wdata[31];
                base    <= wdata[ADDR_W-1:0];
            end
            if (ld1) begin
                old_len <= wdata[LEN_W-1:0];
                cb_len  <= wdata[16 +: LEN_W];
            end
        end
    end

    assign cb_m1     = cb_len - LEN_W'(1);
    assign last_beat = (cb_len == '0) ? '0 : cb_m1[LEN_W-1:LANE_LOG];

    // R1
    ld_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld1 |-> !ld0);

endmodule

// File: rtl/harq_out_steer.sv
module harq_out_steer #(
    parameter int NUM_DEC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic       sop,
    input  logic       eop,
    input  logic       sel,
    input  logic [1:0] afull,
    output logic       ready,
    output logic [1:0] wr,
    output logic [1:0] sop_o,
    output logic [1:0] eop_o
);

    assign ready = !afull[sel];

    for (genvar k = 0; k < 2; k++) begin : g_stream
        if (k < NUM_DEC) begin : g_on
            assign wr[k] = push && (sel == 1'(k)) && !afull[k];
        end else begin : g_off
            assign wr[k] = 1'b0;
        end
        assign sop_o[k] = wr[k] && sop;
        assign eop_o[k] = wr[k] && eop;
    end

    // R10
    one_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr));

endmodule

// File: rtl/harq_combiner.sv
module harq_combiner #(
    parameter int LLR_W   = 6,
    parameter int NLANE   = 32,
    parameter int ADDR_W  = 26,
    parameter int MEM_W   = 192,
    parameter int NUM_DEC = 2,
    localparam int PAY_W  = NLANE * LLR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [31:0]       cfg_data,
    input  logic              in_avail,
    output logic              in_rd,
    input  logic [PAY_W-1:0]  in_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_read,
    output logic              mem_write,
    output logic [MEM_W-1:0]  mem_wdata,
    input  logic [MEM_W-1:0]  mem_rdata,
    input  logic              mem_rvalid,
    input  logic              mem_waitreq,
    output logic              d0_wr,
    output logic              d0_sop,
    output logic              d0_eop,
    output logic [PAY_W-1:0]  d0_data,
    input  logic              d0_afull,
    output logic              d1_wr,
    output logic              d1_sop,
    output logic              d1_eop,
    output logic [PAY_W-1:0]  d1_data,
    input  logic              d1_afull
);

    import harq_pkg::*;

    localparam int LANE_LOG = $clog2(NLANE);
    localparam int LEN_W    = HQ_LEN_W;
    localparam int BEAT_W   = LEN_W - LANE_LOG;

    hq_state_e state_q, state_d;

    logic [BEAT_W-1:0] beat_q;
    logic              sel_q;
    logic [PAY_W-1:0]  new_q, old_q, res_q, sum_w;

    logic              no_comb;
    logic [ADDR_W-1:0] base;
    logic [LEN_W-1:0]  old_len, cb_len;
    logic [BEAT_W-1:0] last_beat;

    logic ld0, ld1, need_rd, is_last;
    logic push, ready, emit_fire;
    logic [1:0] wr_v, sop_v, eop_v;

    assign ld0       = (state_q == S_IDLE) && cfg_wr;
    assign ld1       = (state_q == S_CFG1) && cfg_wr;
    assign is_last   = (beat_q == last_beat);
    assign need_rd   = !no_comb && ({beat_q, {LANE_LOG{1'b0}}} < old_len);
    assign emit_fire = push && ready;

    harq_cfg_regs #(
        .ADDR_W   (ADDR_W),
        .LANE_LOG (LANE_LOG)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld0       (ld0),
        .ld1       (ld1),
        .wdata     (cfg_data),
        .no_comb   (no_comb),
        .base      (base),
        .old_len   (old_len),
        .cb_len    (cb_len),
        .last_beat (last_beat)
    );

    // lane-wise merge: stored value counts only inside the old length
    for (genvar j = 0; j < NLANE; j++) begin : g_lane
        logic [LEN_W-1:0] idx;
        logic [LLR_W-1:0] old_lane;
        assign idx      = {beat_q, LANE_LOG'(j)};
        assign old_lane = (!no_comb && (idx < old_len)) ? old_q[j*LLR_W +: LLR_W] : '0;
        harq_sat_add #(.W(LLR_W)) u_add (
            .a (new_q[j*LLR_W +: LLR_W]),
            .b (old_lane),
            .y (sum_w[j*LLR_W +: LLR_W])
        );
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (cfg_wr)       state_d = S_CFG1;
            S_CFG1:    if (cfg_wr)       state_d = S_FETCH;
            S_FETCH:   if (in_avail)     state_d = need_rd ? S_RD_REQ : S_MERGE;
            S_RD_REQ:  if (!mem_waitreq) state_d = S_RD_WAIT;
            S_RD_WAIT: if (mem_rvalid)   state_d = S_MERGE;
            S_MERGE:                     state_d = S_WR_REQ;
            S_WR_REQ:  if (!mem_waitreq) state_d = S_EMIT;
            S_EMIT:    if (ready)        state_d = is_last ? S_IDLE : S_FETCH;
            default:                     state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // outputs
    always_comb begin
        in_rd     = 1'b0;
        mem_read  = 1'b0;
        mem_write = 1'b0;
        push      = 1'b0;
        unique case (state_q)
            S_FETCH:  in_rd     = in_avail;
            S_RD_REQ: mem_read  = 1'b1;
            S_WR_REQ: mem_write = 1'b1;
            S_EMIT:   push      = 1'b1;
            default:  ;
        endcase
    end

    assign mem_addr  = base + ADDR_W'(beat_q);
    assign mem_wdata = MEM_W'(res_q);

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
            sel_q  <= 1'b0;
            new_q  <= '0;
            old_q  <= '0;
            res_q  <= '0;
        end else begin
            if (ld1)
                beat_q <= '0;
            if (in_rd)
                new_q <= in_data;
            if ((state_q == S_RD_WAIT) && mem_rvalid)
                old_q <= mem_rdata[PAY_W-1:0];
            if (state_q == S_MERGE)
                res_q <= sum_w;
            if (emit_fire) begin
                if (is_last)
                    sel_q <= (NUM_DEC > 1) ? ~sel_q : 1'b0;
                else
                    beat_q <= beat_q + 1'b1;
            end
        end
    end

    harq_out_steer #(.NUM_DEC(NUM_DEC)) u_steer (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .sop   (beat_q == '0),
        .eop   (is_last),
        .sel   (sel_q),
        .afull ({d1_afull, d0_afull}),
        .ready (ready),
        .wr    (wr_v),
        .sop_o (sop_v),
        .eop_o (eop_v)
    );

    assign d0_wr   = wr_v[0];
    assign d1_wr   = wr_v[1];
    assign d0_sop  = sop_v[0];
    assign d1_sop  = sop_v[1];
    assign d0_eop  = eop_v[0];
    assign d1_eop  = eop_v[1];
    assign d0_data = res_q;
    assign d1_data = res_q;

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_read && mem_waitreq) |=> (mem_read && $stable(mem_addr)));

    // R8
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_write && mem_waitreq) |=> (mem_write && $stable(mem_addr) && $stable(mem_wdata)));

    // R9
    eop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d0_eop || d1_eop) |=> (state_q == S_IDLE));

    // R11
    afull_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !ready) |=> (push && $stable(beat_q) && $stable(res_q)));

    // R3
    one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({in_rd, mem_read, mem_write, d0_wr | d1_wr}));

endmodule

// File: tb/test_harq_combiner.sv
module test_harq_combiner;

    localparam int W  = 6;
    localparam int NL = 32;
    localparam int PW = W * NL;
    localparam int MW = 192;
    localparam int AW = 26;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          cfg_wr = 1'b0;
    logic [31:0]   cfg_data = '0;
    logic          in_avail = 1'b0;
    logic          in_rd;
    logic [PW-1:0] in_data = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_read, mem_write;
    logic [MW-1:0] mem_wdata;
    logic [MW-1:0] mem_rdata = '0;
    logic          mem_rvalid = 1'b0, mem_waitreq = 1'b0;
    logic          d0_wr, d0_sop, d0_eop, d0_afull = 1'b0;
    logic          d1_wr, d1_sop, d1_eop, d1_afull = 1'b0;
    logic [PW-1:0] d0_data, d1_data;

    harq_combiner i_harq_combiner (.*);

    int checks = 0, fails = 0, cyc = 0;
    logic [MW-1:0] mem_m [0:63];
    logic [PW-1:0] src_mem [0:15];
    logic [PW-1:0] exp_d [0:15];
    logic [PW-1:0] got_d [0:15];
    bit  got_sop [0:15], got_eop [0:15];
    int  got_str [0:15], got_cyc [0:15];
    int  got_n = 0, exp_str = 0;
    int  src_idx = 0, src_n = 0;
    bit  rd_seen = 0, gap_en = 0, stall_en = 0, hold_pend = 0, done = 0;
    int  rd_cnt = 0, n_rd = 0, n_wr = 0, hold_err = 0, afull_err = 0;
    int  af_lo = 0, af_hi = 0;
    logic [5:0]    rd_addr = '0;
    logic [AW-1:0] hold_addr = '0;

    initial for (int i = 0; i < 64; i++) mem_m[i] = '0;

    task automatic chk(input string tag, input logic [MW-1:0] act, input logic [MW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] gen(int mode, int seed, int b, int j);
        int v;
        if (mode == 1) v = (j % 2 == 1) ? 31 : -32;
        else v = ((seed * 7 + b * 13 + j * 5) % 64) - 32;
        return v[W-1:0];
    endfunction

    function automatic logic [W-1:0] sadd(logic [W-1:0] a, logic [W-1:0] b);
        int s;
        s = $signed(a) + $signed(b);
        if (s > 31) s = 31;
        if (s < -32) s = -32;
        return s[W-1:0];
    endfunction

    // environment: input source, memory model, monitors (all away from the rising edge)
    always @(negedge clk) begin
        cyc++;
        if (rd_seen && src_idx < 16) src_idx++;
        in_avail = (src_idx < src_n) && !(gap_en && (cyc % 4 != 0));
        in_data  = (src_idx < 16) ? src_mem[src_idx] : '0;
        mem_waitreq = stall_en && (cyc % 3 != 0);
        mem_rvalid = 1'b0;
        if (rd_cnt > 0) begin
            rd_cnt--;
            if (rd_cnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem_m[rd_addr];
            end
        end
        d0_afull = (cyc >= af_lo) && (cyc < af_hi);
        d1_afull = d0_afull;
        #1;
        rd_seen = in_rd;
        if (rst_n) begin
            if (hold_pend && (!(mem_read || mem_write) || mem_addr != hold_addr)) hold_err++;
            hold_pend = (mem_read || mem_write) && mem_waitreq;
            hold_addr = mem_addr;
            if (mem_read && !mem_waitreq) begin
                rd_cnt = 2; rd_addr = mem_addr[5:0]; n_rd++;
            end
            if (mem_write && !mem_waitreq) begin
                mem_m[mem_addr[5:0]] = mem_wdata; n_wr++;
            end
            if ((d0_wr && d0_afull) || (d1_wr && d1_afull)) afull_err++;
            if ((d0_wr || d1_wr) && got_n < 16) begin
                got_d[got_n]   = d0_wr ? d0_data : d1_data;
                got_sop[got_n] = d0_wr ? d0_sop : d1_sop;
                got_eop[got_n] = d0_wr ? d0_eop : d1_eop;
                got_str[got_n] = d0_wr ? 0 : 1;
                got_cyc[got_n] = cyc;
                got_n++;
            end
        end
    end

    task automatic send_cfg(input logic [31:0] w0, input logic [31:0] w1);
        @(negedge clk); cfg_wr = 1'b1; cfg_data = w0;
        @(negedge clk); cfg_data = w1;
        @(negedge clk); cfg_wr = 1'b0; cfg_data = '0;
    endtask

    // runs one code block and checks framing, data, stream, memory traffic and contents
    task automatic run_block(input string dtag, input int base, input bit nocomb, input int old_len,
                             input int cb_len, input int mode, input int seed, input bit inject);
        int nb, xr, rd0, wr0;
        logic [W-1:0] nv, ov;
        nb = (cb_len == 0) ? 1 : (cb_len + 31) / 32;
        xr = 0;
        for (int b = 0; b < nb; b++) begin
            if (!nocomb && b * 32 < old_len) xr++;
            for (int j = 0; j < NL; j++) begin
                nv = gen(mode, seed, b, j);
                src_mem[b][j*W +: W] = nv;
                ov = (!nocomb && (b * 32 + j < old_len)) ? mem_m[base + b][j*W +: W] : '0;
                exp_d[b][j*W +: W] = sadd(nv, ov);
            end
        end
        got_n = 0; rd0 = n_rd; wr0 = n_wr; src_idx = 0; src_n = nb;
        send_cfg({nocomb, 5'b0, 26'(base)}, {1'b0, 15'(cb_len), 1'b0, 15'(old_len)});
        if (inject) begin
            repeat (3) @(negedge clk);
            send_cfg({1'b1, 5'b0, 26'd60}, {1'b0, 15'd32, 1'b0, 15'd0});
        end
        for (int t = 0; t < 3000 && got_n < nb; t++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R9 decoder write count", got_n, nb);
        for (int b = 0; b < nb && b < got_n; b++) begin
            chk($sformatf("%s data beat %0d", dtag, b), got_d[b], exp_d[b]);
            chk($sformatf("R9 sop beat %0d", b), got_sop[b], b == 0);
            chk($sformatf("R9 eop beat %0d", b), got_eop[b], b == nb - 1);
            chk($sformatf("R10 stream beat %0d", b), got_str[b], exp_str);
            chk($sformatf("R7 stored beat %0d", b), mem_m[base + b], MW'(exp_d[b]));
        end
        chk("R4 read count", n_rd - rd0, xr);
        chk("R7 write count", n_wr - wr0, nb);
        chk("R3 beats consumed", src_idx, nb);
        src_n = 0;
        exp_str ^= 1;
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        chk("R2 reset quiet", {in_rd, mem_read, mem_write, d0_wr, d1_wr}, 5'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 idle after reset", {in_rd, mem_read, mem_write, d0_wr, d1_wr}, 5'b0);
    endtask

    task automatic t_first_tx();
        run_block("R6", 4, 1'b1, 50, 100, 0, 1, 1'b0);
    endtask

    task automatic t_combine();
        stall_en = 1;
        run_block("R4", 4, 1'b0, 70, 100, 0, 3, 1'b0);
        stall_en = 0;
    endtask

    task automatic t_saturate();
        run_block("R6", 40, 1'b1, 0, 64, 1, 0, 1'b0);
        run_block("R5", 40, 1'b0, 64, 64, 1, 0, 1'b0);
        run_block("R5", 40, 1'b0, 64, 64, 0, 5, 1'b0);
    endtask

    task automatic t_afull();
        af_lo = cyc; af_hi = cyc + 60;
        run_block("R11", 24, 1'b1, 0, 40, 0, 9, 1'b0);
        chk("R11 first write after almost-full drops", got_cyc[0] >= af_hi, 1'b1);
        af_lo = 0; af_hi = 0;
    endtask

    task automatic t_gaps();
        gap_en = 1;
        run_block("R3", 20, 1'b0, 0, 33, 0, 11, 1'b0);
        gap_en = 0;
    endtask

    task automatic t_single();
        run_block("R9", 30, 1'b1, 0, 1, 0, 13, 1'b0);
    endtask

    task automatic t_ignore_cfg();
        run_block("R12", 10, 1'b1, 0, 64, 0, 17, 1'b1);
        chk("R12 untouched address", mem_m[60], '0);
    endtask

    initial begin
        t_reset();
        t_first_tx();
        t_combine();
        t_saturate();
        t_afull();
        t_gaps();
        t_single();
        t_ignore_cfg();
        chk("R8 request held under wait-request", hold_err, 0);
        chk("R11 no write while almost full", afull_err, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R3 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule